// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block gathers eight interrupt request lines, holds them in a request register, and raises a single interrupt line toward the processor. The processor reaches it through a byte-wide register port with one address bit. An even-address write whose bit 4 is set starts a configuration sequence. That sequence takes one to three further odd-address bytes. Once the sequence ends, odd-address writes load the mask. Even-address writes that are not the sequence start act as commands: end-of-interrupt, poll, and read-back selection.

Acknowledge is done in software. A poll command arms the next even-address read. That read returns the winning level together with a present flag, and it moves that level from the request register into the in-service register. Priority is fixed: line 0 is the highest and line 7 the lowest. A request wins only if it ranks above every level already in service, so higher-priority requests can nest inside lower-priority ones. A poll that finds nothing returns level 7 with the flag clear. Reading the in-service register afterwards shows that level 7 is not in service, which is how software recognises a spurious request.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the mask register is 0xFF, the request and in-service registers are 0, even-address reads return the request register, and `cpu_int` is low.
- R2: An even-address write with bit 4 set clears the mask, request and in-service registers and any pending poll, and selects the request register for reads. It then expects odd-address bytes in this order: a vector byte, a cascade byte only when bit 1 of the starting byte is 0, and a mode byte only when bit 0 of the starting byte is 1. Until the last expected byte has arrived, odd writes leave the mask unchanged and `cpu_int` stays low.
- R3: Once configuration is complete, an odd-address write loads the mask. A set bit blocks that line from `cpu_int` and from polls. An odd-address read returns the mask.
- R4: A rising edge on `irq_in[i]` sets request bit i whatever the mask says. A line held high does not set its bit again after the bit has been cleared.
- R5: `cpu_int` is high exactly when configuration is complete and some unmasked request bit has a lower index than every set in-service bit.
- R6: After the even-address write 0x0C, the next even-address read returns 0x80 | L, where L is the winning level. On that read L is set in service and request bit L is cleared. Only that one read is a poll response.
- R7: A poll read that finds no winning request returns 0x07, with bit 7 clear, and changes no register.
- R8: The even-address write 0x0B selects the in-service register and 0x0A selects the request register for later even-address reads. The selection persists across polls.
- R9: The even-address write 0x20 clears the lowest-index set bit of the in-service register. Other writes with bits 4:3 = 00 and bits 7:5 ≠ 001 leave the in-service register unchanged.
- R10: While level k is in service, a request on a line below k raises `cpu_int`, and requests on lines k and above do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_odd | input | 1 | Address bit: 1 selects the odd register |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe; a poll read is consumed at the clock edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from state and address |
| irq_in | input | 8 | Interrupt request lines, assumed synchronous to clk |
| cpu_int | output | 1 | Interrupt request to the processor |

## Verification
`rd_data` is combinational, so the bench compares it 1 ns after it drives a read, before the clock edge, against a bench model of the register state. Every register effect, including a new edge on an input, a write, and the in-service marking of a poll read, is due at the next rising edge. `cpu_int` therefore settles one edge after the stimulus and is checked just after that edge and again before the next drive. Directed sequences pin literal values for nesting, end-of-interrupt, empty poll, masking and the three configuration lengths. Constrained-random traffic then mixes line toggles with commands.

// File: rtl/pic_pkg.sv
package pic_pkg;
    parameter int PIC_N = 8;
    localparam int LVL_W = $clog2(PIC_N);

    typedef enum logic [2:0] {
        SEQ_IDLE, SEQ_VEC, SEQ_CAS, SEQ_MODE, SEQ_RUN
    } pic_seq_e;

    typedef struct packed {
        logic [PIC_N-1:0] mask;
        logic [PIC_N-1:0] isr;
        logic [PIC_N-1:0] irr;
        pic_seq_e         seq;
        logic             want_cas;
        logic             want_mode;
        logic             show_isr;
        logic             poll_armed;
    } pic_state_t;

    localparam logic [2:0] CMD_EOI_NS = 3'b001;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic         hit,
    output logic [W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = i[W-1:0];
            end
        end
    end
endmodule

// File: rtl/pic_edge.sv
module pic_edge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb prev_d = lines;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_bit
        assign rise[g] = lines[g] & ~prev_q[g];
    end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_odd,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [PIC_N-1:0] wr_data,
    output logic [PIC_N-1:0] rd_data,
    input  logic [PIC_N-1:0] irq_in,
    output logic             cpu_int
);
    pic_state_t       st_d, st_q;
    logic [PIC_N-1:0] rise;
    logic             req_hit, isr_hit, grant;
    logic [LVL_W-1:0] req_idx, isr_idx;
    logic             start_wr, poll_rd;
    logic [PIC_N-1:0] poll_word;

    pic_edge #(.N(PIC_N)) u_edge (
        .clk(clk), .rst_n(rst_n), .lines(irq_in), .rise(rise)
    );

    pic_prio #(.N(PIC_N)) u_req_prio (
        .vec(st_q.irr & ~st_q.mask), .hit(req_hit), .idx(req_idx)
    );

    pic_prio #(.N(PIC_N)) u_isr_prio (
        .vec(st_q.isr), .hit(isr_hit), .idx(isr_idx)
    );

    assign grant    = req_hit && (!isr_hit || (req_idx < isr_idx));
    assign start_wr = wr_en && !sel_odd && wr_data[4];
    assign poll_rd  = rd_en && !sel_odd && st_q.poll_armed;

    always_comb begin
        if (grant) poll_word = {1'b1, {(PIC_N-1-LVL_W){1'b0}}, req_idx};
        else       poll_word = {{(PIC_N-LVL_W){1'b0}}, {LVL_W{1'b1}}};
    end

    always_comb begin
        if (sel_odd)              rd_data = st_q.mask;
        else if (st_q.poll_armed) rd_data = poll_word;
        else if (st_q.show_isr)   rd_data = st_q.isr;
        else                      rd_data = st_q.irr;
    end

    assign cpu_int = (st_q.seq == SEQ_RUN) && grant;

    always_comb begin
        st_d     = st_q;
        st_d.irr = st_q.irr | rise;
        if (poll_rd) begin
            st_d.poll_armed = 1'b0;
            if (grant) begin
                st_d.isr[req_idx] = 1'b1;
                st_d.irr[req_idx] = 1'b0;
            end
        end
        if (wr_en && !sel_odd) begin
            if (wr_data[4]) begin
                st_d.mask       = '0;
                st_d.isr        = '0;
                st_d.irr        = '0;
                st_d.show_isr   = 1'b0;
                st_d.poll_armed = 1'b0;
                st_d.want_cas   = !wr_data[1];
                st_d.want_mode  = wr_data[0];
                st_d.seq        = SEQ_VEC;
            end else if (wr_data[3]) begin
                if (wr_data[2]) st_d.poll_armed = 1'b1;
                if (wr_data[1]) st_d.show_isr   = wr_data[0];
            end else if (wr_data[7:5] == CMD_EOI_NS && isr_hit) begin
                st_d.isr[isr_idx] = 1'b0;
            end
        end
        if (wr_en && sel_odd) begin
            case (st_q.seq)
                SEQ_VEC:  st_d.seq = st_q.want_cas ? SEQ_CAS :
                                     (st_q.want_mode ? SEQ_MODE : SEQ_RUN);
                SEQ_CAS:  st_d.seq = st_q.want_mode ? SEQ_MODE : SEQ_RUN;
                SEQ_MODE: st_d.seq = SEQ_RUN;
                SEQ_RUN:  st_d.mask = wr_data;
                default:  st_d.seq = st_q.seq;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.mask       <= '1;
            st_q.seq        <= SEQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: no request reaches the processor before configuration ends
    a_r2_quiet_in_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.seq != SEQ_RUN) |-> !cpu_int);

    // R3: mask only moves on a run-time odd write or a sequence start
    a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && sel_odd && st_q.seq == SEQ_RUN) && !start_wr) |=> $stable(st_q.mask));

    // R4: every detected edge lands in the request register
    a_r4_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_wr && !poll_rd && rise != '0) |=> ((st_q.irr & $past(rise)) == $past(rise)));

    // R6: a granted poll read puts the reported level in service
    a_r6_poll_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_rd && grant && !wr_en) |=> st_q.isr[$past(req_idx)] && !st_q.poll_armed);

    // R7: an empty poll reports level 7 without the present flag
    a_r7_empty_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_rd && !grant) |-> (rd_data == 8'h07));

    // R9: a non-specific end-of-interrupt retires exactly one level
    a_r9_eoi_one: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_odd && wr_data == 8'h20 && st_q.isr != '0 && !rd_en)
        |=> ($countones(st_q.isr) + 1 == $countones($past(st_q.isr))));
endmodule

// File: tb/sim_pic8_ctrl.sv
module sim_pic8_ctrl;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_odd = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0, irq_in = '0;
    logic [7:0] rd_data;
    logic       cpu_int;

    int n_tests = 0, n_fail = 0;

    // bench model
    logic [7:0] m_mask, m_isr, m_irr, m_prev;
    int         m_seq;  // 0 idle, 1 vector, 2 cascade, 3 mode, 4 run
    logic       m_cas, m_mode, m_sel, m_poll;
    logic [7:0] irq_v = '0;
    logic [7:0] last_rd;

    pic8_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sel_odd(sel_odd), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq_in(irq_in), .cpu_int(cpu_int)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic int lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic logic m_grant();
        int r = lowest(m_irr & ~m_mask);
        return (r < 8) && (r < lowest(m_isr));
    endfunction

    function automatic logic [7:0] m_read(input logic odd);
        int r = lowest(m_irr & ~m_mask);
        if (odd) return m_mask;
        if (m_poll) return m_grant() ? (8'h80 | 8'(r)) : 8'h07;
        return m_sel ? m_isr : m_irr;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic op(input logic we, input logic re, input logic odd,
                      input logic [7:0] d, input string req);
        int          r;
        logic        g;
        logic [7:0]  rise;
        @(negedge clk);
        chk("R5 cpu_int", {7'd0, cpu_int}, {7'd0, (m_seq == 4) && m_grant()});
        wr_en = we; rd_en = re; sel_odd = odd; wr_data = d; irq_in = irq_v;
        #1;
        if (re) begin
            last_rd = rd_data;
            chk(req, rd_data, m_read(odd));
        end
        r    = lowest(m_irr & ~m_mask);
        g    = m_grant();
        rise = irq_v & ~m_prev;
        @(posedge clk);
        #1;
        m_prev = irq_v;
        m_irr  = m_irr | rise;
        if (re && !odd && m_poll) begin
            m_poll = 1'b0;
            if (g) begin m_isr[r] = 1'b1; m_irr[r] = 1'b0; end
        end
        if (we && !odd) begin
            if (d[4]) begin
                m_mask = 0; m_isr = 0; m_irr = 0; m_sel = 0; m_poll = 0;
                m_cas = !d[1]; m_mode = d[0]; m_seq = 1;
            end else if (d[3]) begin
                if (d[2]) m_poll = 1'b1;
                if (d[1]) m_sel = d[0];
            end else if (d[7:5] == 3'b001 && m_isr != 0) begin
                m_isr[lowest(m_isr)] = 1'b0;
            end
        end
        if (we && odd) begin
            case (m_seq)
                1: m_seq = m_cas ? 2 : (m_mode ? 3 : 4);
                2: m_seq = m_mode ? 3 : 4;
                3: m_seq = 4;
                4: m_mask = d;
                default: ;
            endcase
        end
        wr_en = 0; rd_en = 0;
    endtask

    task automatic wr(input logic odd, input logic [7:0] d, input string req);
        op(1'b1, 1'b0, odd, d, req);
    endtask

    task automatic rd(input logic odd, input string req);
        op(1'b0, 1'b1, odd, 8'h00, req);
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_mask = 8'hFF; m_isr = 0; m_irr = 0; m_prev = 0; m_seq = 0;
        m_cas = 0; m_mode = 0; m_sel = 0; m_poll = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(1'b1, "R1 mask"); chk("R1 mask literal", last_rd, 8'hFF);
        rd(1'b0, "R1 irr");  chk("R1 irr literal", last_rd, 8'h00);
        chk("R1 cpu_int", {7'd0, cpu_int}, 8'h00);

        // R2 full sequence: start, vector, cascade, mode
        wr(1'b0, 8'h11, "R2 start");
        rd(1'b1, "R2 mask cleared"); chk("R2 mask cleared", last_rd, 8'h00);
        irq_v = 8'h08;
        wr(1'b1, 8'h00, "R2 vector");
        chk("R2 no int in setup", {7'd0, cpu_int}, 8'h00);
        wr(1'b1, 8'h04, "R2 cascade");
        rd(1'b1, "R2 mask untouched"); chk("R2 mask untouched", last_rd, 8'h00);
        wr(1'b1, 8'h01, "R2 mode");
        chk("R2 int after setup", {7'd0, cpu_int}, 8'h01);

        // R6 / R8 / R10 / R9 nesting
        wr(1'b0, 8'h0C, "R6 poll"); rd(1'b0, "R6 poll read");
        chk("R6 level3", last_rd, 8'h83);
        wr(1'b0, 8'h0B, "R8 sel isr"); rd(1'b0, "R8 isr");
        chk("R8 isr", last_rd, 8'h08);
        irq_v = 8'h28; wr(1'b0, 8'h0B, "R10 low req");
        chk("R10 lower blocked", {7'd0, cpu_int}, 8'h00);
        irq_v = 8'h2A; wr(1'b0, 8'h0B, "R10 high req");
        chk("R10 higher nests", {7'd0, cpu_int}, 8'h01);
        wr(1'b0, 8'h0C, "R6 poll"); rd(1'b0, "R6 nested");
        chk("R6 level1", last_rd, 8'h81);
        rd(1'b0, "R8 isr persists"); chk("R8 isr persists", last_rd, 8'h0A);
        wr(1'b0, 8'h20, "R9 eoi"); rd(1'b0, "R9 isr");
        chk("R9 eoi clears 1", last_rd, 8'h08);
        wr(1'b0, 8'h60, "R9 other cmd"); rd(1'b0, "R9 isr kept");
        chk("R9 other ignored", last_rd, 8'h08);
        wr(1'b0, 8'h20, "R9 eoi");
        chk("R5 level5 pending", {7'd0, cpu_int}, 8'h01);
        wr(1'b0, 8'h0C, "R6 poll"); rd(1'b0, "R6 level5");
        chk("R6 level5", last_rd, 8'h85);
        wr(1'b0, 8'h20, "R9 eoi");
        // R7 empty poll and spurious view
        wr(1'b0, 8'h0C, "R7 poll"); rd(1'b0, "R7 empty");
        chk("R7 empty poll", last_rd, 8'h07);
        rd(1'b0, "R7 isr"); chk("R7 no level7 in service", last_rd, 8'h00);
        // R4 held lines do not re-request
        wr(1'b0, 8'h0A, "R8 sel irr"); rd(1'b0, "R4 irr");
        chk("R4 held no reset", last_rd, 8'h00);
        // R3 mask
        wr(1'b1, 8'hFF, "R3 mask all"); rd(1'b1, "R3 readback");
        chk("R3 readback", last_rd, 8'hFF);
        irq_v = 8'h6A; wr(1'b0, 8'h0A, "R4 masked edge");
        chk("R3 masked no int", {7'd0, cpu_int}, 8'h00);
        rd(1'b0, "R4 masked latched"); chk("R4 masked latched", last_rd, 8'h40);

        // R2 shorter sequences
        wr(1'b0, 8'h13, "R2 start no cascade");
        wr(1'b1, 8'h20, "R2 vector"); wr(1'b1, 8'h01, "R2 mode");
        wr(1'b1, 8'h5A, "R2 mask now"); rd(1'b1, "R2 short");
        chk("R2 two bytes", last_rd, 8'h5A);
        wr(1'b0, 8'h12, "R2 start vector only");
        wr(1'b1, 8'h20, "R2 vector");
        wr(1'b1, 8'hC3, "R2 mask now"); rd(1'b1, "R2 shortest");
        chk("R2 one byte", last_rd, 8'hC3);
        wr(1'b1, 8'h00, "R3 unmask");

        // constrained random against the model
        for (int i = 0; i < 1500; i++) begin
            int k = $urandom % 9;
            if ($urandom % 3 == 0) irq_v[$urandom % 8] = ~irq_v[$urandom % 8];
            case (k)
                0: wr(1'b0, 8'h0C, "R6 rand poll");
                1, 2: rd(1'b0, "R6 rand even read");
                3: wr(1'b0, 8'h20, "R9 rand eoi");
                4: wr(1'b1, 8'($urandom & $urandom & $urandom), "R3 rand mask");
                5: wr(1'b0, 8'h0B, "R8 rand isr");
                6: wr(1'b0, 8'h0A, "R8 rand irr");
                7: rd(1'b1, "R3 rand mask read");
                default: op(1'b0, 1'b0, 1'b0, 8'h00, "R4 rand idle");
            endcase
        end
        op(1'b0, 1'b0, 1'b0, 8'h00, "R5 final");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule